// File: doc/BRIEF.md
# Code Flash Byte-Programming Controller

This block is the device-side controller for a small on-chip code store. A programmer, or firmware acting as one, presents an address, a data byte, a mode selection and a program-enable level. An active-low program strobe starts each operation. The store comes out of reset blank, with every location at 0xFF.

A single strobe pulse starts a self-timed byte write. A write can only clear bits: the stored byte becomes the old value ANDed with the new one. Only a whole-array erase brings bits back to one. An erase requires the strobe to be held low for a long, fixed number of cycles.

While a write is running, the host can watch either the ready/busy output or the data-polling readback. Two lock bits can be programmed through the same timed write. Once either lock bit is set, verify readback is blocked until the next erase. Three fixed identification bytes are always readable in signature mode.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset, `rdy` is 1, and a verify read (mode 3'b010) of any address returns 0xFF.
- R2: A rising edge of `prog_n` starts a write when `mode` is 3'b001 (code byte) and `pgm_en` is 1. `rdy` goes low at the clock edge that samples the rise. It stays low for exactly WR_CYC cycles, and then the array holds the result.
- R3: A code write stores the old byte ANDed with the new one, so bits only ever change from 1 to 0.
- R4: During a code write, a verify read of the address being written returns the complement of the new bit 7 in bit 7. Bits 6:0 still show the old stored value.
- R5: A strobe rise is ignored when `pgm_en` is 0. It is also ignored while a write is in progress. Neither the array nor `rdy` is affected.
- R6: Chip erase uses mode 3'b110 with `pgm_en` at 1. If `prog_n` is held low for ERASE_CYC consecutive cycles, every byte is set to 0xFF and both lock bits are cleared.
- R7: An erase strobe released before ERASE_CYC cycles leaves the array and lock bits unchanged.
- R8: Modes 3'b100 and 3'b101 program lock bit 1 and lock bit 2 through the same timed write. While either lock bit is set, verify reads return 0xFF.
- R9: Signature mode 3'b011 returns 0x1E at address 0x30 and 0x51 at 0x31. At 0x32 it returns 0xFF when LOW_VOLT=0 and 0x05 when LOW_VOLT=1. Any other address returns 0xFF.
- R10: `dout` is registered and reflects the mode and address sampled at the previous clock edge. Modes other than verify and signature read 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | AW | Byte address |
| din | input | 8 | Data byte to program |
| mode | input | 3 | Operation select |
| pgm_en | input | 1 | Program-enable level; must be 1 for write, lock and erase |
| prog_n | input | 1 | Active-low program strobe |
| dout | output | 8 | Registered readback byte |
| rdy | output | 1 | 1 = ready, 0 = write in progress |

## Verification
The bench builds the block with WR_CYC=8 and ERASE_CYC=20. At these values, a full write window fits in a handful of cycles. This makes it possible to count the busy time exactly and to place a polling read and a second, ignored strobe inside a single write. An erase held three cycles short, and one held two cycles past the limit, then show both sides of the hold threshold. LOW_VOLT=1 selects the 0x05 identification byte, so the variant-specific third signature value is checked against a value other than the blank pattern.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [2:0] {
    M_IDLE   = 3'b000,
    M_PROG   = 3'b001,
    M_VERIFY = 3'b010,
    M_SIG    = 3'b011,
    M_LOCK1  = 3'b100,
    M_LOCK2  = 3'b101,
    M_ERASE  = 3'b110,
    M_RSVD   = 3'b111
  } fpc_mode_e;

  typedef enum logic [1:0] {
    OP_CODE = 2'd0,
    OP_LK1  = 2'd1,
    OP_LK2  = 2'd2
  } fpc_op_e;
endpackage

// File: rtl/fpc_strobe.sv
module fpc_strobe #(
  parameter int ERASE_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  input  logic erase_arm,
  output logic rise,
  output logic erase_go
);
  localparam int CW = (ERASE_CYC > 1) ? $clog2(ERASE_CYC) : 1;

  logic          prog_q;
  logic [CW-1:0] hold_q, hold_d;
  logic          done_q, done_d;

  assign rise     = prog_n & ~prog_q;
  assign erase_go = erase_arm & ~prog_n & ~done_q & (hold_q == CW'(ERASE_CYC - 1));

  always_comb begin
    hold_d = hold_q;
    done_d = done_q;
    if (!erase_arm || prog_n) begin
      hold_d = '0;
      done_d = 1'b0;
    end else if (!done_q) begin
      if (erase_go) done_d = 1'b1;
      else          hold_d = hold_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= 1'b1;
      hold_q <= '0;
      done_q <= 1'b0;
    end else begin
      prog_q <= prog_n;
      hold_q <= hold_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/fpc_wtimer.sv
module fpc_wtimer
  import flash_prog_pkg::*;
#(
  parameter int AW     = 6,
  parameter int WR_CYC = 1500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  fpc_op_e       start_op,
  input  logic [AW-1:0] start_addr,
  input  logic [7:0]    start_data,
  output logic          busy,
  output logic          commit,
  output fpc_op_e       op,
  output logic [AW-1:0] wa,
  output logic [7:0]    wd
);
  localparam int TW = (WR_CYC > 1) ? $clog2(WR_CYC) : 1;

  logic [TW-1:0] cnt_q, cnt_d;
  logic          busy_d;
  fpc_op_e       op_d;
  logic [AW-1:0] wa_d;
  logic [7:0]    wd_d;

  assign commit = busy & (cnt_q == '0);

  always_comb begin
    busy_d = busy;
    cnt_d  = cnt_q;
    op_d   = op;
    wa_d   = wa;
    wd_d   = wd;
    if (busy) begin
      if (commit) busy_d = 1'b0;
      else        cnt_d  = cnt_q - TW'(1);
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = TW'(WR_CYC - 1);
      op_d   = start_op;
      wa_d   = start_addr;
      wd_d   = start_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      op    <= OP_CODE;
      wa    <= '0;
      wd    <= 8'hFF;
    end else begin
      busy  <= busy_d;
      cnt_q <= cnt_d;
      op    <= op_d;
      wa    <= wa_d;
      wd    <= wd_d;
    end
  end

  // R5: a start request during a running write must not disturb the latched target
  a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !commit && start |=> $stable(wa) && $stable(wd) && busy);
endmodule

// File: rtl/fpc_array.sv
module fpc_array #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase,
  input  logic          wr_en,
  input  logic [AW-1:0] wa,
  input  logic [7:0]    wd,
  input  logic [AW-1:0] ra,
  output logic [7:0]    rd
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  assign rd = mem[ra];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wr_en) begin
      mem[wa] <= mem[wa] & wd;
    end
  end

  // R3: programming never raises a bit
  a_r3_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !erase |=> (mem[$past(wa)] & ~$past(mem[wa])) == 8'h00);
  // R6: erase leaves blank bytes at both ends of the array
  a_r6_erase_blank: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF);
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int AW        = 6,
  parameter int WR_CYC    = 1500,
  parameter int ERASE_CYC = 10000,
  parameter bit LOW_VOLT  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  input  logic [2:0]    mode,
  input  logic          pgm_en,
  input  logic          prog_n,
  output logic [7:0]    dout,
  output logic          rdy
);
  localparam logic [7:0] SIG_THIRD = LOW_VOLT ? 8'h05 : 8'hFF;

  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  fpc_mode_e     md;
  logic          rise, erase_go, busy, commit, start, cmd_ok, locked;
  fpc_op_e       start_op, op;
  logic [AW-1:0] wa;
  logic [7:0]    wd, rd;
  logic          lock1_q, lock1_d, lock2_q, lock2_d;
  logic [7:0]    dout_d;

  assign md = fpc_mode_e'(mode);

  fpc_strobe #(.ERASE_CYC(ERASE_CYC)) u_strobe (
    .clk(clk), .rst_n(srst_n), .prog_n(prog_n),
    .erase_arm(md == M_ERASE && pgm_en && !busy),
    .rise(rise), .erase_go(erase_go)
  );

  always_comb begin
    cmd_ok   = 1'b1;
    start_op = OP_CODE;
    case (md)
      M_PROG:  start_op = OP_CODE;
      M_LOCK1: start_op = OP_LK1;
      M_LOCK2: start_op = OP_LK2;
      default: cmd_ok   = 1'b0;
    endcase
  end
  assign start = rise & pgm_en & cmd_ok;

  fpc_wtimer #(.AW(AW), .WR_CYC(WR_CYC)) u_timer (
    .clk(clk), .rst_n(srst_n), .start(start), .start_op(start_op),
    .start_addr(addr), .start_data(din),
    .busy(busy), .commit(commit), .op(op), .wa(wa), .wd(wd)
  );

  fpc_array #(.AW(AW)) u_array (
    .clk(clk), .rst_n(srst_n), .erase(erase_go),
    .wr_en(commit && op == OP_CODE), .wa(wa), .wd(wd),
    .ra(addr), .rd(rd)
  );

  assign locked = lock1_q | lock2_q;

  always_comb begin
    lock1_d = lock1_q;
    lock2_d = lock2_q;
    if (erase_go) begin
      lock1_d = 1'b0;
      lock2_d = 1'b0;
    end else if (commit) begin
      if (op == OP_LK1) lock1_d = 1'b1;
      if (op == OP_LK2) lock2_d = 1'b1;
    end
  end

  always_comb begin
    dout_d = 8'hFF;
    case (md)
      M_VERIFY: begin
        if (locked)                                     dout_d = 8'hFF;
        else if (busy && op == OP_CODE && addr == wa)   dout_d = {~wd[7], rd[6:0]};
        else                                            dout_d = rd;
      end
      M_SIG: begin
        if      (addr == AW'('h30)) dout_d = 8'h1E;
        else if (addr == AW'('h31)) dout_d = 8'h51;
        else if (addr == AW'('h32)) dout_d = SIG_THIRD;
        else                        dout_d = 8'hFF;
      end
      default: dout_d = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      lock1_q <= 1'b0;
      lock2_q <= 1'b0;
      dout    <= 8'hFF;
    end else begin
      lock1_q <= lock1_d;
      lock2_q <= lock2_d;
      dout    <= dout_d;
    end
  end

  assign rdy = ~busy;

  // R2, R5: ready only drops after a strobe rise seen with the enable level high
  a_r5_start_gated: assert property (@(posedge clk) disable iff (!srst_n)
    $fell(rdy) |-> $past(prog_n) && $past(pgm_en));
  // R8: a set lock bit forces blank verify data
  a_r8_lock_blank: assert property (@(posedge clk) disable iff (!srst_n)
    $past(md == M_VERIFY && locked) |-> dout == 8'hFF);
  // R10: idle mode reads blank
  a_r10_idle_blank: assert property (@(posedge clk) disable iff (!srst_n)
    $past(md == M_IDLE) |-> dout == 8'hFF);
endmodule

// File: tb/sim_flash_prog_ctrl.sv
module sim_flash_prog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int WR = 8;
  localparam int ER = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = 8'h00;
  logic [2:0]    mode = 3'b000;
  logic          pgm_en = 1'b0;
  logic          prog_n = 1'b1;
  logic [7:0]    dout;
  logic          rdy;

  int n_chk = 0;
  int n_bad = 0;
  logic [8:0] exp_q [$];
  string      tag_q [$];
  event       sample_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_ctrl #(.AW(AW), .WR_CYC(WR), .ERASE_CYC(ER), .LOW_VOLT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .mode(mode),
    .pgm_en(pgm_en), .prog_n(prog_n), .dout(dout), .rdy(rdy)
  );

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        logic [8:0] e;
        string      t;
        logic [7:0] act;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        act = e[8] ? {7'b0, rdy} : dout;
        n_chk++;
        if (act !== e[7:0]) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", t, act, e[7:0]);
        end
      end
    end
  end

  task automatic push(input bit is_rdy, input logic [7:0] e, input string t);
    exp_q.push_back({is_rdy, e});
    tag_q.push_back(t);
    ->sample_ev;
    #0;
  endtask

  task automatic rd(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    mode = m; addr = a;
    @(negedge clk);
    push(1'b0, e, t);
  endtask

  task automatic strobe(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    mode = m; addr = a; din = d; pgm_en = en; prog_n = 1'b0;
    @(negedge clk);
    prog_n = 1'b1;
    @(negedge clk);
    mode = 3'b000; pgm_en = 1'b0;
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 1;
    while (!rdy && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic erase_hold(input int n);
    @(negedge clk);
    mode = 3'b110; pgm_en = 1'b1; prog_n = 1'b0;
    repeat (n) @(negedge clk);
    prog_n = 1'b1;
    @(negedge clk);
    mode = 3'b000; pgm_en = 1'b0;
  endtask

  initial begin
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    push(1'b1, 8'h01, "R1 rdy after reset");
    rd(3'b010, 6'd0,  8'hFF, "R1 blank addr 0");
    rd(3'b010, 6'd63, 8'hFF, "R1 blank addr 63");
    rd(3'b000, 6'd5,  8'hFF, "R10 idle mode reads FF");

    // write A5 to 3; strobe task ends one negedge after the rise edge
    strobe(3'b001, 6'd3, 8'hA5, 1'b1);
    push(1'b1, 8'h00, "R2 rdy low after strobe");
    rd(3'b010, 6'd3, 8'h7F, "R4 polling shows inverted bit7");
    wait_ready(c);
    push(1'b1, 8'h01, "R2 rdy back high");
    if (c != WR - 1) begin
      n_bad++;
      $display("FAIL R2 busy length: actual %0d expected %0d", c + 2, WR + 1);
    end
    n_chk++;
    rd(3'b010, 6'd3, 8'hA5, "R2 data stored");

    strobe(3'b001, 6'd3, 8'h3C, 1'b1);
    wait_ready(c);
    rd(3'b010, 6'd3, 8'h24, "R3 AND of old and new");

    // second strobe inside a running write
    strobe(3'b001, 6'd10, 8'hF0, 1'b1);
    strobe(3'b001, 6'd11, 8'h00, 1'b1);
    wait_ready(c);
    push(1'b1, 8'h01, "R5 busy not extended");
    rd(3'b010, 6'd10, 8'hF0, "R5 first write landed");
    rd(3'b010, 6'd11, 8'hFF, "R5 strobe while busy ignored");

    strobe(3'b001, 6'd12, 8'h00, 1'b0);
    push(1'b1, 8'h01, "R5 no busy without enable");
    rd(3'b010, 6'd12, 8'hFF, "R5 disabled strobe ignored");

    rd(3'b011, 6'h30, 8'h1E, "R9 signature byte 0");
    rd(3'b011, 6'h31, 8'h51, "R9 signature byte 1");
    rd(3'b011, 6'h32, 8'h05, "R9 signature byte 2 low-voltage");
    rd(3'b011, 6'h33, 8'hFF, "R9 other address");

    erase_hold(ER - 3);
    rd(3'b010, 6'd3, 8'h24, "R7 short erase no change");

    strobe(3'b100, 6'd0, 8'h00, 1'b1);
    wait_ready(c);
    rd(3'b010, 6'd3,  8'hFF, "R8 lock blocks verify");
    rd(3'b010, 6'd10, 8'hFF, "R8 lock blocks verify 2");
    rd(3'b011, 6'h31, 8'h51, "R9 signature while locked");

    erase_hold(ER + 2);
    strobe(3'b001, 6'd3, 8'h12, 1'b1);
    wait_ready(c);
    rd(3'b010, 6'd3,  8'h12, "R6 erase restored ones and cleared lock");
    rd(3'b010, 6'd10, 8'hFF, "R6 erased byte");

    strobe(3'b101, 6'd0, 8'h00, 1'b1);
    wait_ready(c);
    rd(3'b010, 6'd3, 8'hFF, "R8 lock bit 2 blocks verify");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule